// File: doc/BRIEF.md
# Two-Channel Host DMA Mailbox Handshake Controller

This block links a local processor to an 8-bit host expansion bus through a one-byte DMA mailbox. Firmware places a byte in the transmit mailbox and sets a per-channel request bit. While that channel is enabled, the block raises a DMA request toward the host's DMA controller. The host answers with an active-low acknowledge and then a read or a write strobe. On a read, the block drives the transmit byte onto the tri-state host data bus. On a write, it captures the host byte into the receive mailbox. When the strobe ends, the request bit clears, and firmware polls that bit to pace the transfer one byte at a time.

There are two channels. Each has its own request bit, enable bit, request output and acknowledge input. The two mailbox data registers are shared, and the acknowledge that is active decides which channel's request bit the strobe clears. Host strobes and acknowledges are asynchronous. The request output and the bus drive follow the raw pins directly. The request-bit clear and the receive capture run on synchronized copies.

Top module: `hdma_mailbox`

## Requirements
- R1: A local write to address 0 loads the control register. Channel c's request bit is at bit 2c and its enable bit is at bit 2c+1, so a 1 sets the bit and a 0 clears it. A request bit rises and an enable bit changes only through such a write.
- R2: While rst_n is low at a clock edge, all request and enable bits and the receive byte clear. The request outputs are low, host_data_dis_n is high and the host data bus is not driven.
- R3: host_drq[c] is high exactly when channel c's request bit is 1, its enable bit is 1 and host_dack_n[c] is high. It follows these without a clock.
- R4: host_drq[c] falls as soon as host_dack_n[c] goes low. The request bit stays 1 through the whole acknowledged strobe.
- R5: A rising edge of the combined strobe (host_rd_n AND host_wr_n) while host_dack_n[c] is low clears request bit c, whatever the state of the enable bit. The clear is visible within 4 clocks of the edge.
- R6: While some channel c has its enable bit at 1 and host_dack_n[c] low, a low host_wr_n makes the block capture host_data into the receive register, which is read at local address 2.
- R7: The transmit byte (written and read at local address 1) drives host_data exactly while some channel is enabled and acknowledged and host_rd_n is low. The drive is released as soon as host_rd_n rises. host_data_dis_n is low exactly while the bus is driven.
- R8: With no acknowledge the request stays pending indefinitely. A control write that clears the request bit drops host_drq[c] by the next clock.
- R9: The channels work independently. A strobe acknowledged only on channel 1 leaves channel 0's request bit untouched.
- R10: A strobe on a channel whose enable bit is 0, or one made while no acknowledge is low, neither drives the bus nor changes the receive byte.
- R11: A local read of address 0 returns the current request and enable bits at the positions given in R1, with 0 in the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_wr_en | input | 1 | Local register write strobe |
| loc_addr | input | 2 | Local register address, used for both read and write |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data for loc_addr |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_dack_n | input | 2 | Per-channel DMA acknowledge, active low |
| host_drq | output | 2 | Per-channel DMA request |
| host_data | inout | 8 | Tri-state host data bus |
| host_data_dis_n | output | 1 | Low while the transmit mailbox drives the bus |

## Verification
The request outputs, the bus drive and host_data_dis_n are combinational from the pins. The bench therefore checks them 1 ns after it changes a pin, inside the same clock period. A local register write lands at the rising edge after the bench drives it, so its effect is sampled at the following falling edge. The request-bit clear and the receive capture pass through a two-flop synchronizer and an edge register, which puts them up to three rising edges after the strobe edge. The bench waits four clocks before it reads them back over the local port. It also reads the request bit while the strobe is still low, to confirm that the bit has not cleared early.

// File: rtl/hdma_pkg.sv
// Package: shared register selector and control-bit placement for the host
// DMA mailbox. Assumes two bits per channel in the control register.
package hdma_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TX   = 2'd1,
        REG_RX   = 2'd2
    } reg_sel_e;

    // Bit index of a channel's request bit in the control register.
    function automatic int req_pos(input int ch);
        return 2 * ch;
    endfunction

    // Bit index of a channel's enable bit in the control register.
    function automatic int en_pos(input int ch);
        return 2 * ch + 1;
    endfunction

endpackage

// File: rtl/hdma_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous host pins.
// Assumes every bit is an independent level. Reset loads IDLE, the inactive
// pin level, so that no edge is seen when reset is released.
module hdma_sync #(
    parameter int          W    = 4,
    parameter logic [W-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta_q;
            logic stab_q;

            // Two-stage resynchronization of one pin.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= IDLE[i];
                    stab_q <= IDLE[i];
                end else begin
                    meta_q <= async_in[i];
                    stab_q <= meta_q;
                end
            end

            assign sync_out[i] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/hdma_chan.sv
// Module: request and enable state for one host DMA channel. Assumes
// ack_n_s comes from the synchronizer and strobe_rise is one clock wide.
// A firmware write has priority over a clear by the host in the same clock.
module hdma_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic fw_wr,
    input  logic fw_req,
    input  logic fw_en,
    input  logic ack_n_raw,
    input  logic ack_n_s,
    input  logic strobe_rise,
    output logic req_q,
    output logic en_q,
    output logic drq
);

    // Request and enable bits: loaded by firmware, request cleared at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            en_q  <= 1'b0;
        end else if (fw_wr) begin
            req_q <= fw_req;
            en_q  <= fw_en;
        end else if (strobe_rise && !ack_n_s) begin
            req_q <= 1'b0;
        end
    end

    // Request pin: dropped immediately by the raw acknowledge.
    always_comb begin
        drq = rst_n & req_q & en_q & ack_n_raw;
    end

endmodule

// File: rtl/hdma_datapath.sv
// Module: shared transmit and receive mailbox bytes plus the host bus drive
// enable. Assumes the host holds data stable while its write strobe is low.
// The drive follows the raw pins. The receive capture uses synchronized ones.
module hdma_datapath #(
    parameter int DW  = 8,
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_wr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] en_q,
    input  logic [NCH-1:0] ack_n_raw,
    input  logic [NCH-1:0] ack_n_s,
    input  logic           rd_n_raw,
    input  logic           wr_n_s,
    input  logic [DW-1:0]  bus_in,
    output logic [DW-1:0]  tx_q,
    output logic [DW-1:0]  rx_q,
    output logic           bus_oe
);

    logic sel_raw;
    logic sel_sync;

    // Some enabled channel is acknowledged, on raw and on synchronized pins.
    always_comb begin
        sel_raw  = |(en_q & ~ack_n_raw);
        sel_sync = |(en_q & ~ack_n_s);
        bus_oe   = rst_n & sel_raw & ~rd_n_raw;
    end

    // Transmit mailbox byte, loaded by firmware.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (tx_wr) begin
            tx_q <= wdata;
        end
    end

    // Receive mailbox byte, captured during an acknowledged host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sel_sync && !wr_n_s) begin
            rx_q <= bus_in;
        end
    end

endmodule

// File: rtl/hdma_mailbox.sv
// Module: top of the two-channel host DMA mailbox. Decodes the local
// register port, synchronizes the host pins, finds the end-of-strobe edge
// and instantiates one channel block per DMA channel. Assumes 2*NCH <= DW.
module hdma_mailbox #(
    parameter int DW     = 8,
    parameter int NCH    = 2,
    parameter int LOC_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_wr_en,
    input  logic [LOC_AW-1:0] loc_addr,
    input  logic [DW-1:0]     loc_wdata,
    output logic [DW-1:0]     loc_rdata,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [NCH-1:0]    host_dack_n,
    output logic [NCH-1:0]    host_drq,
    inout  wire  [DW-1:0]     host_data,
    output logic              host_data_dis_n
);
    import hdma_pkg::*;

    localparam int SW = NCH + 2;

    logic [SW-1:0]  pins_s;
    logic           rd_n_s;
    logic           wr_n_s;
    logic [NCH-1:0] ack_n_s;
    logic           strobe_d;
    logic           strobe_rise;
    logic           ctrl_wr;
    logic           tx_wr;
    logic [NCH-1:0] req_q;
    logic [NCH-1:0] en_q;
    logic [DW-1:0]  ctrl_view;
    logic [DW-1:0]  tx_q;
    logic [DW-1:0]  rx_q;
    logic           bus_oe;

    hdma_sync #(.W(SW), .IDLE({SW{1'b1}})) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_dack_n, host_wr_n, host_rd_n}),
        .sync_out (pins_s)
    );

    // Split the synchronized pin vector and decode local writes.
    always_comb begin
        rd_n_s  = pins_s[0];
        wr_n_s  = pins_s[1];
        ack_n_s = pins_s[SW-1:2];
        ctrl_wr = loc_wr_en && (loc_addr == LOC_AW'(REG_CTRL));
        tx_wr   = loc_wr_en && (loc_addr == LOC_AW'(REG_TX));
    end

    // Previous combined strobe level, used to find the end of a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_d <= 1'b1;
        end else begin
            strobe_d <= rd_n_s & wr_n_s;
        end
    end

    // One-clock pulse when the combined strobe returns high.
    always_comb begin
        strobe_rise = rd_n_s & wr_n_s & ~strobe_d;
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            hdma_chan u_chan (
                .clk         (clk),
                .rst_n       (rst_n),
                .fw_wr       (ctrl_wr),
                .fw_req      (loc_wdata[req_pos(c)]),
                .fw_en       (loc_wdata[en_pos(c)]),
                .ack_n_raw   (host_dack_n[c]),
                .ack_n_s     (ack_n_s[c]),
                .strobe_rise (strobe_rise),
                .req_q       (req_q[c]),
                .en_q        (en_q[c]),
                .drq         (host_drq[c])
            );
        end
    endgenerate

    hdma_datapath #(.DW(DW), .NCH(NCH)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_wr     (tx_wr),
        .wdata     (loc_wdata),
        .en_q      (en_q),
        .ack_n_raw (host_dack_n),
        .ack_n_s   (ack_n_s),
        .rd_n_raw  (host_rd_n),
        .wr_n_s    (wr_n_s),
        .bus_in    (host_data),
        .tx_q      (tx_q),
        .rx_q      (rx_q),
        .bus_oe    (bus_oe)
    );

    // Pack the request and enable bits into the control register layout.
    always_comb begin
        ctrl_view = '0;
        for (int c = 0; c < NCH; c++) begin
            ctrl_view[req_pos(c)] = req_q[c];
            ctrl_view[en_pos(c)]  = en_q[c];
        end
    end

    // Local read mux.
    always_comb begin
        case (loc_addr)
            LOC_AW'(REG_CTRL): loc_rdata = ctrl_view;
            LOC_AW'(REG_TX):   loc_rdata = tx_q;
            LOC_AW'(REG_RX):   loc_rdata = rx_q;
            default:           loc_rdata = '0;
        endcase
    end

    assign host_data       = bus_oe ? tx_q : {DW{1'bz}};
    assign host_data_dis_n = ~bus_oe;

endmodule

// File: rtl/hdma_mailbox_chk.sv
// Module: assertion checker for hdma_mailbox, bound to every instance.
// Assumes the synchronous active-low reset of the top module.
module hdma_mailbox_chk #(
    parameter int DW     = 8,
    parameter int NCH    = 2,
    parameter int LOC_AW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loc_wr_en,
    input logic [LOC_AW-1:0] loc_addr,
    input logic [DW-1:0]     loc_wdata,
    input logic              host_rd_n,
    input logic [NCH-1:0]    host_dack_n,
    input logic [NCH-1:0]    host_drq,
    input logic              host_data_dis_n,
    input logic [NCH-1:0]    req_q,
    input logic [NCH-1:0]    en_q
);

    AST_EN_ONLY_BY_FW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(loc_wr_en) |-> $stable(en_q)); // R1

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_n |-> host_data_dis_n); // R7

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            AST_REQ_RISE_BY_FW: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(req_q[c]) |-> $past(loc_wr_en)); // R1

            AST_DRQ_NEEDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
                host_drq[c] |-> (req_q[c] && en_q[c])); // R3

            AST_ACK_DROPS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
                !host_dack_n[c] |-> !host_drq[c]); // R4

            AST_ABORT_DROPS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(loc_wr_en) && ($past(loc_addr) == '0) && !$past(loc_wdata[2*c]))
                |-> !host_drq[c]); // R8
        end
    endgenerate

endmodule

bind hdma_mailbox hdma_mailbox_chk #(.DW(DW), .NCH(NCH), .LOC_AW(LOC_AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .loc_wr_en       (loc_wr_en),
    .loc_addr        (loc_addr),
    .loc_wdata       (loc_wdata),
    .host_rd_n       (host_rd_n),
    .host_dack_n     (host_dack_n),
    .host_drq        (host_drq),
    .host_data_dis_n (host_data_dis_n),
    .req_q           (req_q),
    .en_q            (en_q)
);

// File: tb/hdma_mailbox_tb.sv
// Bench for hdma_mailbox: a vector table for the request-pin gating, then
// directed tests of read, write, abort, channel independence and reset.
module hdma_mailbox_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loc_wr_en = 1'b0;
    logic [1:0] loc_addr = 2'd0;
    logic [7:0] loc_wdata = 8'd0;
    logic [7:0] loc_rdata;
    logic       host_rd_n = 1'b1;
    logic       host_wr_n = 1'b1;
    logic [1:0] host_dack_n = 2'b11;
    logic [1:0] host_drq;
    wire  [7:0] host_data;
    logic       host_data_dis_n;
    logic       tb_oe = 1'b0;
    logic [7:0] tb_dat = 8'd0;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    assign host_data = tb_oe ? tb_dat : 8'bz;

    always #5 clk = ~clk;

    hdma_mailbox u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .loc_wr_en       (loc_wr_en),
        .loc_addr        (loc_addr),
        .loc_wdata       (loc_wdata),
        .loc_rdata       (loc_rdata),
        .host_rd_n       (host_rd_n),
        .host_wr_n       (host_wr_n),
        .host_dack_n     (host_dack_n),
        .host_drq        (host_drq),
        .host_data       (host_data),
        .host_data_dis_n (host_data_dis_n)
    );

    // Vector table: {req0, en0, dack0_n, expected drq0}
    localparam logic [3:0] VEC [8] = '{
        4'b0000, 4'b0010, 4'b0100, 4'b0110,
        4'b1000, 4'b1010, 4'b1100, 4'b1111
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fw_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        loc_wr_en = 1'b1;
        loc_addr  = a;
        loc_wdata = d;
        @(negedge clk);
        loc_wr_en = 1'b0;
    endtask

    task automatic fw_read(input logic [1:0] a, output logic [7:0] d);
        loc_addr = a;
        #1;
        d = loc_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        wait_clk(3);
        // R2: reset state
        chk("R2 drq", 32'(host_drq), 32'h0);
        chk("R2 dis_n", 32'(host_data_dis_n), 32'h1);
        rst_n = 1'b1;
        wait_clk(1);
        fw_read(2'd0, rd);
        chk("R11 ctrl after reset", 32'(rd), 32'h0);

        // R3: table walk on channel 0
        for (int i = 0; i < 8; i++) begin
            fw_write(2'd0, {6'd0, VEC[i][2], VEC[i][3]});
            host_dack_n[0] = VEC[i][1];
            #1;
            chk("R3 drq gating", 32'(host_drq[0]), 32'(VEC[i][0]));
            host_dack_n[0] = 1'b1;
        end

        // R4, R7, R5: host DMA read on channel 0
        fw_write(2'd1, 8'hA5);
        fw_write(2'd0, 8'h03);
        #1;
        chk("R3 drq raised", 32'(host_drq[0]), 32'h1);
        fw_read(2'd0, rd);
        chk("R11 ctrl readback", 32'(rd), 32'h03);
        host_dack_n[0] = 1'b0;
        #1;
        chk("R4 drq drops on ack", 32'(host_drq[0]), 32'h0);
        wait_clk(1);
        host_rd_n = 1'b0;
        #1;
        chk("R7 bus driven", 32'(host_data), 32'hA5);
        chk("R7 dis_n low", 32'(host_data_dis_n), 32'h0);
        wait_clk(4);
        fw_read(2'd0, rd);
        chk("R4 req held during strobe", 32'(rd[0]), 32'h1);
        host_rd_n = 1'b1;
        #1;
        chk("R7 released at rd rise", 32'(host_data_dis_n), 32'h1);
        wait_clk(4);
        fw_read(2'd0, rd);
        chk("R5 req cleared at strobe end", 32'(rd), 32'h02);
        host_dack_n[0] = 1'b1;

        // R9, R6: host write on channel 1 leaves channel 0 alone
        fw_write(2'd0, 8'h0F);
        host_dack_n[1] = 1'b0;
        #1;
        chk("R9 ch0 drq unaffected", 32'(host_drq), 32'h1);
        tb_dat = 8'h3C;
        tb_oe  = 1'b1;
        wait_clk(1);
        host_wr_n = 1'b0;
        wait_clk(4);
        host_wr_n = 1'b1;
        wait_clk(4);
        tb_oe = 1'b0;
        host_dack_n[1] = 1'b1;
        fw_read(2'd2, rd);
        chk("R6 rx captured", 32'(rd), 32'h3C);
        fw_read(2'd0, rd);
        chk("R9 only ch1 req cleared", 32'(rd), 32'h0B);

        // R10: strobes on a disabled channel
        fw_write(2'd0, 8'h01);
        host_dack_n[0] = 1'b0;
        tb_dat = 8'h77;
        tb_oe  = 1'b1;
        wait_clk(1);
        host_wr_n = 1'b0;
        wait_clk(4);
        host_wr_n = 1'b1;
        wait_clk(2);
        tb_dat = 8'h5A;
        host_rd_n = 1'b0;
        #1;
        chk("R10 no drive when disabled", 32'(host_data_dis_n), 32'h1);
        chk("R10 bus holds bench value", 32'(host_data), 32'h5A);
        host_rd_n = 1'b1;
        wait_clk(4);
        tb_oe = 1'b0;
        host_dack_n[0] = 1'b1;
        fw_read(2'd2, rd);
        chk("R10 rx unchanged", 32'(rd), 32'h3C);
        fw_read(2'd0, rd);
        chk("R5 clear ignores enable", 32'(rd), 32'h00);

        // R10: strobe with no acknowledge
        fw_write(2'd0, 8'h03);
        tb_dat = 8'h99;
        tb_oe  = 1'b1;
        host_wr_n = 1'b0;
        wait_clk(4);
        host_wr_n = 1'b1;
        wait_clk(4);
        tb_oe = 1'b0;
        fw_read(2'd2, rd);
        chk("R10 no capture without ack", 32'(rd), 32'h3C);

        // R8: request persists without acknowledge, then abort
        wait_clk(20);
        fw_read(2'd0, rd);
        chk("R8 req pending", 32'(rd), 32'h03);
        chk("R8 drq pending", 32'(host_drq[0]), 32'h1);
        fw_write(2'd0, 8'h00);
        #1;
        chk("R8 abort drops drq", 32'(host_drq[0]), 32'h0);

        // R1: a write of 0 clears only what it names
        fw_write(2'd0, 8'h0C);
        fw_read(2'd0, rd);
        chk("R1 set ch1 bits", 32'(rd), 32'h0C);
        fw_write(2'd0, 8'h08);
        fw_read(2'd0, rd);
        chk("R1 clear ch1 req", 32'(rd), 32'h08);
        fw_read(2'd1, rd);
        chk("R7 tx readback", 32'(rd), 32'hA5);

        // R2: reset in the middle of operation
        fw_write(2'd0, 8'h0F);
        @(negedge clk);
        rst_n = 1'b0;
        wait_clk(2);
        chk("R2 drq cleared", 32'(host_drq), 32'h0);
        fw_read(2'd0, rd);
        chk("R2 ctrl cleared", 32'(rd), 32'h00);
        fw_read(2'd2, rd);
        chk("R2 rx cleared", 32'(rd), 32'h00);
        rst_n = 1'b1;
        wait_clk(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule